// File: doc/BRIEF.md
# APB Wait-State Extension Monitor

This block is a passive observer placed on an APB bus between one manager and its subordinates. On every rising clock edge it samples the select, enable, ready, address, direction, write data, strobe, protection and read data lines. It judges whether a transfer that the subordinate has stretched with wait states is held perfectly still. A low ready answer must leave every request line and the select frozen, and it must keep enable asserted. It also checks that the setup phase takes one cycle and that enable never appears without select. Each rule that is broken raises a sticky flag. The first broken rule after a clear is recorded, together with the address on the bus at that moment.

The monitor also measures traffic. A stretched transfer counts as one transfer. It is counted once, on the edge where select, enable and ready are all high. It goes into one of three bins by the number of cycles it spent waiting, and into a read or a write bank. Read data is copied out only on the completing edge of a read. A synchronous clear returns all of this to zero without disturbing the monitor's one-cycle memory of the bus.

Top module: `apb_hold_monitor`

## Requirements
- R1: After active-low reset, and on the edge after `clr` is sampled high, `viol`, `first_vld`, `first_code`, `first_addr`, `rdata_cap` and all six counters read zero. `clr` takes precedence over anything else seen on the same edge.
- R2: An edge is "held" when psel=1, penable=1 and pready=0. If the following edge shows a different value, a sticky flag is set: `viol[0]` for paddr, `viol[1]` for pwrite, `viol[2]` for pwdata, `viol[3]` for pstrb and `viol[4]` for pprot.
- R3: psel low on the edge after a held edge sets `viol[5]`.
- R4: penable low on the edge after a held edge sets `viol[6]`.
- R5: A transfer whose request lines stay frozen raises no flag, whatever the number of wait cycles and whatever prdata does.
- R6: psel high with penable low on two edges in a row sets `viol[7]`.
- R7: penable high while psel is low sets `viol[8]`.
- R8: Each completion (psel, penable and pready all high) adds one to exactly one counter. The bin is chosen by the held edges before it: 0, 1, or 2 and more. The bank is chosen by pwrite on the completing edge: 0 selects `rd_cnt*` and 1 selects `wr_cnt*`.
- R9: `rdata_cap` takes prdata only on the completing edge of a read. Held edges and writes leave it unchanged.
- R10: Counters stop at their all-ones value instead of wrapping.
- R11: The first violation after reset or clear sets `first_vld` and latches `first_code`, which is the index of the lowest flag raised on that edge plus one. It also latches the paddr present on that edge. Later violations do not change these until the next clear.
- R12: A completion on an edge that also breaks a rule both raises the flag and is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of flags, capture and counters |
| psel | input | 1 | Observed select |
| penable | input | 1 | Observed enable |
| pready | input | 1 | Observed ready |
| paddr | input | AW | Observed address |
| pwrite | input | 1 | Observed direction, 1 = write |
| pwdata | input | DW | Observed write data |
| pstrb | input | DW/8 | Observed byte strobes |
| pprot | input | 3 | Observed protection attributes |
| prdata | input | DW | Observed read data |
| viol | output | 9 | Sticky rule flags, bit positions per R2 to R7 |
| first_vld | output | 1 | A first violation has been recorded |
| first_code | output | 4 | Rule code of the first violation |
| first_addr | output | AW | paddr at the first violation |
| rdata_cap | output | DW | Last completed read data |
| rd_cnt0 | output | CW | Reads with no wait cycle |
| rd_cnt1 | output | CW | Reads with one wait cycle |
| rd_cnt2 | output | CW | Reads with two or more wait cycles |
| wr_cnt0 | output | CW | Writes with no wait cycle |
| wr_cnt1 | output | CW | Writes with one wait cycle |
| wr_cnt2 | output | CW | Writes with two or more wait cycles |

## Verification
The completing edge is also the edge on which a drift is judged. So a rule check and a counter update can fall on the same clock. The bench provokes this by changing one request line, one at a time, on the edge that follows a held edge while ready is high. For each case it expects exactly one flag bit and its code, and exactly one count in the one-wait bin of the direction present on that edge. When the drifting line is pwrite, that is a read, and the captured read data is checked as well.

// File: rtl/apb_hold_monitor.sv
module apb_hold_monitor #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic            pclk,
  input  logic            presetn,
  input  logic            clr,
  input  logic            psel,
  input  logic            penable,
  input  logic            pready,
  input  logic [AW-1:0]   paddr,
  input  logic            pwrite,
  input  logic [DW-1:0]   pwdata,
  input  logic [DW/8-1:0] pstrb,
  input  logic [2:0]      pprot,
  input  logic [DW-1:0]   prdata,
  output logic [8:0]      viol,
  output logic            first_vld,
  output logic [3:0]      first_code,
  output logic [AW-1:0]   first_addr,
  output logic [DW-1:0]   rdata_cap,
  output logic [CW-1:0]   rd_cnt0,
  output logic [CW-1:0]   rd_cnt1,
  output logic [CW-1:0]   rd_cnt2,
  output logic [CW-1:0]   wr_cnt0,
  output logic [CW-1:0]   wr_cnt1,
  output logic [CW-1:0]   wr_cnt2
);
  localparam int SW = DW / 8;
  localparam int NR = 9;
  localparam logic [1:0] HMAX = 2'd2;

  logic            held_q, setup_q;
  logic [AW-1:0]   q_addr;
  logic            q_write;
  logic [DW-1:0]   q_wdata;
  logic [SW-1:0]   q_strb;
  logic [2:0]      q_prot;
  logic [1:0]      hcnt;
  logic [NR-1:0]   hit;
  logic [3:0]      code_n;
  logic [CW-1:0]   cnt [0:1][0:2];

  wire held_now = psel & penable & ~pready;
  wire done     = psel & penable & pready;

  assign hit[0] = held_q && (paddr  != q_addr);
  assign hit[1] = held_q && (pwrite != q_write);
  assign hit[2] = held_q && (pwdata != q_wdata);
  assign hit[3] = held_q && (pstrb  != q_strb);
  assign hit[4] = held_q && (pprot  != q_prot);
  assign hit[5] = held_q && !psel;
  assign hit[6] = held_q && !penable;
  assign hit[7] = setup_q && psel && !penable;
  assign hit[8] = penable && !psel;

  always_comb begin
    code_n = '0;
    for (int i = NR - 1; i >= 0; i--)
      if (hit[i]) code_n = 4'(i + 1);
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      held_q  <= 1'b0;
      setup_q <= 1'b0;
      q_addr  <= '0;
      q_write <= 1'b0;
      q_wdata <= '0;
      q_strb  <= '0;
      q_prot  <= '0;
    end else begin
      held_q  <= held_now;
      setup_q <= psel & ~penable;
      q_addr  <= paddr;
      q_write <= pwrite;
      q_wdata <= pwdata;
      q_strb  <= pstrb;
      q_prot  <= pprot;
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      viol       <= '0;
      first_vld  <= 1'b0;
      first_code <= '0;
      first_addr <= '0;
    end else if (clr) begin
      viol       <= '0;
      first_vld  <= 1'b0;
      first_code <= '0;
      first_addr <= '0;
    end else begin
      viol <= viol | hit;
      if (!first_vld && |hit) begin
        first_vld  <= 1'b1;
        first_code <= code_n;
        first_addr <= paddr;
      end
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)
      hcnt <= '0;
    else if (clr || !held_now)
      hcnt <= '0;
    else if (hcnt != HMAX)
      hcnt <= hcnt + 2'd1;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rdata_cap <= '0;
      for (int d = 0; d < 2; d++)
        for (int b = 0; b < 3; b++)
          cnt[d][b] <= '0;
    end else if (clr) begin
      rdata_cap <= '0;
      for (int d = 0; d < 2; d++)
        for (int b = 0; b < 3; b++)
          cnt[d][b] <= '0;
    end else if (done) begin
      if (!pwrite) rdata_cap <= prdata;
      if (cnt[pwrite][hcnt] != '1)
        cnt[pwrite][hcnt] <= cnt[pwrite][hcnt] + 1'b1;
    end
  end

  assign rd_cnt0 = cnt[0][0];
  assign rd_cnt1 = cnt[0][1];
  assign rd_cnt2 = cnt[0][2];
  assign wr_cnt0 = cnt[1][0];
  assign wr_cnt1 = cnt[1][1];
  assign wr_cnt2 = cnt[1][2];
endmodule

// File: rtl/apb_hold_monitor_chk.sv
module apb_hold_monitor_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input logic            pclk,
  input logic            presetn,
  input logic            clr,
  input logic            psel,
  input logic            penable,
  input logic            pready,
  input logic [AW-1:0]   paddr,
  input logic            pwrite,
  input logic [DW-1:0]   pwdata,
  input logic [DW/8-1:0] pstrb,
  input logic [2:0]      pprot,
  input logic [DW-1:0]   prdata,
  input logic [8:0]      viol,
  input logic            first_vld,
  input logic [3:0]      first_code,
  input logic [AW-1:0]   first_addr,
  input logic [DW-1:0]   rdata_cap,
  input logic [CW-1:0]   rd_cnt0,
  input logic [CW-1:0]   rd_cnt1,
  input logic [CW-1:0]   rd_cnt2,
  input logic [CW-1:0]   wr_cnt0,
  input logic [CW-1:0]   wr_cnt1,
  input logic [CW-1:0]   wr_cnt2
);
  // R1
  clear_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
    clr |=> (viol == '0) && !first_vld && (rdata_cap == '0)
            && (rd_cnt0 == '0) && (rd_cnt1 == '0) && (rd_cnt2 == '0)
            && (wr_cnt0 == '0) && (wr_cnt1 == '0) && (wr_cnt2 == '0));

  // R2
  flag_sticky_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !clr |=> ((viol & $past(viol)) == $past(viol)));

  // R4
  enable_drop_chk: assert property (@(posedge pclk) disable iff (!presetn)
    ($past(psel && penable && !pready) && !penable && !clr) |=> viol[6]);

  // R7
  enable_alone_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (penable && !psel && !clr) |=> viol[8]);

  // R9
  rdata_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (!(psel && penable && pready && !pwrite) && !clr) |=> $stable(rdata_cap));

  // R8
  count_mono_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !clr |=> (rd_cnt0 >= $past(rd_cnt0)) && (rd_cnt1 >= $past(rd_cnt1))
             && (rd_cnt2 >= $past(rd_cnt2)) && (wr_cnt0 >= $past(wr_cnt0))
             && (wr_cnt1 >= $past(wr_cnt1)) && (wr_cnt2 >= $past(wr_cnt2)));

  // R11
  first_keep_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (first_vld && !clr) |=> first_vld && $stable(first_code) && $stable(first_addr));
endmodule

bind apb_hold_monitor apb_hold_monitor_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (.*);

// File: tb/tb_apb_hold_monitor.sv
module tb_apb_hold_monitor;
  localparam int CLK_NS = 10;
  localparam int AW = 16, DW = 32, CW = 8;

  logic pclk = 0, presetn = 0, clr = 0;
  logic psel = 0, penable = 0, pready = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0, prdata = '0;
  logic [3:0] pstrb = '0;
  logic [2:0] pprot = '0;
  logic [8:0] viol;
  logic first_vld;
  logic [3:0] first_code;
  logic [AW-1:0] first_addr;
  logic [DW-1:0] rdata_cap;
  logic [CW-1:0] rd_cnt0, rd_cnt1, rd_cnt2, wr_cnt0, wr_cnt1, wr_cnt2;

  int checks = 0, fails = 0;
  int ex_cnt [0:1][0:2];
  logic [DW-1:0] ex_rdata;
  bit finished = 0;

  always #(CLK_NS/2) pclk = ~pclk;

  apb_hold_monitor #(.AW(AW), .DW(DW), .CW(CW)) dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic s, logic e, logic r);
    psel = s; penable = e; pready = r;
    @(negedge pclk);
  endtask

  task automatic check_counts(string req);
    chk({req, " rd0"}, 64'(rd_cnt0), 64'(ex_cnt[0][0]));
    chk({req, " rd1"}, 64'(rd_cnt1), 64'(ex_cnt[0][1]));
    chk({req, " rd2"}, 64'(rd_cnt2), 64'(ex_cnt[0][2]));
    chk({req, " wr0"}, 64'(wr_cnt0), 64'(ex_cnt[1][0]));
    chk({req, " wr1"}, 64'(wr_cnt1), 64'(ex_cnt[1][1]));
    chk({req, " wr2"}, 64'(wr_cnt2), 64'(ex_cnt[1][2]));
  endtask

  task automatic do_clear();
    clr = 1;
    cyc(0, 0, 0);
    clr = 0;
    for (int d = 0; d < 2; d++) for (int b = 0; b < 3; b++) ex_cnt[d][b] = 0;
    ex_rdata = '0;
    chk("R1 clear viol", 64'(viol), 64'(0));
    chk("R1 clear first_vld", 64'(first_vld), 64'(0));
    chk("R1 clear rdata", 64'(rdata_cap), 64'(0));
    check_counts("R1 clear");
  endtask

  task automatic xfer(logic w, logic [AW-1:0] a, logic [DW-1:0] d, int waits);
    int bin;
    paddr = a; pwrite = w; pwdata = d; pstrb = 4'hF; pprot = 3'b010;
    cyc(1, 0, 0);
    for (int k = 0; k < waits; k++) begin
      prdata = d ^ DW'(k + 32'h1111);
      cyc(1, 1, 0);
    end
    prdata = d;
    cyc(1, 1, 1);
    prdata = '0;
    cyc(0, 0, 0);
    bin = (waits > 2) ? 2 : waits;
    if (ex_cnt[w][bin] < 255) ex_cnt[w][bin]++;
    if (!w) ex_rdata = d;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 2; d++) for (int b = 0; b < 3; b++) ex_cnt[d][b] = 0;
    ex_rdata = '0;
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);
    chk("R1 reset viol", 64'(viol), 64'(0));
    chk("R1 reset first_vld", 64'(first_vld), 64'(0));
    chk("R1 reset rdata", 64'(rdata_cap), 64'(0));
    check_counts("R1 reset");

    // R5 R8 R9: sweep direction x wait count x address
    for (int w = 0; w < 2; w++)
      for (int n = 0; n < 5; n++)
        for (int a = 0; a < 3; a++) begin
          xfer(w[0], AW'(16'h0100 * a + n), 32'hA000_0000 + 32'(w * 256 + n * 16 + a), n);
          check_counts("R8 sweep");
          chk("R9 sweep rdata", 64'(rdata_cap), 64'(ex_rdata));
          chk("R5 sweep no flag", 64'(viol), 64'(0));
        end

    // R2 R12: drift on the completing edge after one held edge
    for (int f = 0; f < 5; f++) begin
      do_clear();
      paddr = 16'h3000; pwrite = 1; pwdata = 32'h1234_5678; pstrb = 4'hF; pprot = 3'b001;
      cyc(1, 0, 0);
      cyc(1, 1, 0);
      case (f)
        0: paddr = 16'h3004;
        1: pwrite = 0;
        2: pwdata = 32'h1234_5679;
        3: pstrb = 4'h3;
        default: pprot = 3'b011;
      endcase
      prdata = 32'h5A5A_0000 + 32'(f);
      cyc(1, 1, 1);
      prdata = '0;
      cyc(0, 0, 0);
      chk("R2 drift flag", 64'(viol), 64'(1 << f));
      chk("R11 drift code", 64'(first_code), 64'(f + 1));
      chk("R11 drift addr", 64'(first_addr), 64'(paddr));
      ex_cnt[pwrite][1] = 1;
      if (!pwrite) ex_rdata = 32'h5A5A_0000 + 32'(f);
      check_counts("R12 drift count");
      chk("R9 drift rdata", 64'(rdata_cap), 64'(ex_rdata));
    end

    // R3: select dropped after held edge (enable also low)
    do_clear();
    paddr = 16'h4000; pwrite = 1;
    cyc(1, 0, 0); cyc(1, 1, 0); cyc(0, 0, 0);
    chk("R3 select drop", 64'(viol), 64'h060);
    chk("R11 select drop code", 64'(first_code), 64'(6));
    check_counts("R8 no completion on drop");

    // R4: enable dropped, select kept
    do_clear();
    cyc(1, 0, 0); cyc(1, 1, 0); cyc(1, 0, 0); cyc(0, 0, 0);
    chk("R4 enable drop", 64'(viol), 64'h040);
    chk("R11 enable drop code", 64'(first_code), 64'(7));

    // R7 then R6: first record must not be overwritten
    do_clear();
    paddr = 16'h0A0A;
    cyc(0, 1, 0);
    paddr = 16'h0B0B;
    cyc(1, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0);
    chk("R7 R6 flags", 64'(viol), 64'h180);
    chk("R11 first code kept", 64'(first_code), 64'(9));
    chk("R11 first addr kept", 64'(first_addr), 64'h0A0A);
    chk("R11 first valid", 64'(first_vld), 64'(1));

    // R6 alone
    do_clear();
    paddr = 16'h0C0C;
    cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 1, 1); cyc(0, 0, 0);
    chk("R6 long setup", 64'(viol), 64'h080);
    chk("R6 code", 64'(first_code), 64'(8));

    // R10: saturation
    do_clear();
    for (int i = 0; i < 260; i++) xfer(1, AW'(i), DW'(i), 0);
    chk("R10 saturate wr0", 64'(wr_cnt0), 64'(255));
    check_counts("R10 saturate");

    // R1: clear wins over a completing edge
    paddr = 16'h1; pwrite = 0; prdata = 32'hDEAD_BEEF;
    cyc(1, 0, 0);
    clr = 1; cyc(1, 1, 1); clr = 0;
    cyc(0, 0, 0);
    for (int d = 0; d < 2; d++) for (int b = 0; b < 3; b++) ex_cnt[d][b] = 0;
    check_counts("R1 clear precedence");
    chk("R1 clear precedence rdata", 64'(rdata_cap), 64'(0));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule